// File: doc/BRIEF.md
# Floppy Read-Pulse Data Window Separator

This block recovers a bit-cell window from the raw pulse stream of a floppy disc drive. The drive's read line is an asynchronous, active-low pulse, one per flux transition. The block captures that line with the master clock and cuts each falling edge down to a shaped pulse of fixed length. A twisted-ring (Johnson) shift register walks a triangular 16-state sequence: it fills with ones and then empties. Each shaped pulse clears it, so the window edges move with the pulses and follow slow changes in motor speed.

The most significant bit of the sequencer drives a toggle flip-flop that forms the window signal. The toggle is applied as a clock enable on the master clock. Every toggle closes one bit cell. At that point the block shifts a 1 into a 16-bit data word if a pulse arrived during the cell, or a 0 if none did, and it raises a one-cycle strobe. After a pulse the next cell boundary comes half a sequence period later, so the pulse sits near the middle of its cell. The block does no MFM decoding and does not search for sync marks.

Top module: `mfm_window_sep`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `win`, `data` and `bit_valid` are all 0.
- R2: When `rd_n` is first sampled low at clock edge N, a strobe carrying a 1 in `data[0]` is registered at edge N+12. This uses the default three synchroniser stages, a two-cycle shaped pulse and an 8-stage sequencer.
- R3: Each falling edge of `rd_n` counts as exactly one pulse, however long `rd_n` then stays low. A low level held for 40 cycles yields a single 1, and the strobes continue every 16 cycles while the level is held.
- R4: With no read pulses, `bit_valid` pulses every 2*SEQ_W = 16 cycles and each strobe shifts in a 0.
- R5: A pulse re-phases the cells. After the strobe that carries the pulse, the next strobe follows exactly 16 cycles later, and no strobe comes in between.
- R6: `win` inverts in exactly the cycle in which `bit_valid` is high, and holds its value in every other cycle.
- R7: On each strobe, `data` shifts one place toward its MSB and the new cell bit enters at bit 0 (1 = a pulse arrived during the cell, 0 = no pulse).
- R8: Pulse trains meet these conditions: the cell period is a constant 76, 80 or 84 ns, or changes from cell to cell among these values; the first cell holds a pulse; and no more than three empty cells come between pulses. For such trains, the bits recovered after the first 1 equal the injected cell pattern, in order.
- R9: `bit_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Asynchronous active-low read pulse from the drive |
| win | output | 1 | Recovered data window; changes level at each cell boundary |
| data | output | DATA_W | Recovered bits; newest bit in bit 0 |
| bit_valid | output | 1 | One-cycle strobe when a cell closes and `data` has shifted |

## Verification
The assertions assume that each low phase and each high phase of `rd_n` lasts at least two master cycles. They also assume that consecutive falling edges are further apart than the shaped pulse, so the shaper is never retriggered while it is counting and the shaped-pulse-length property stays valid. The stimulus keeps within these limits. Read pulses are 12 ns wide, about 2.4 clock periods. Pulses are never closer together than one cell of at least 76 ns. Edges are placed off the clock grid so that the synchroniser captures them at varying phases.

// File: rtl/mfm_sep_pkg.sv
`timescale 1ns/1ps
package mfm_sep_pkg;
  localparam int unsigned DEF_SEQ_W     = 8;
  localparam int unsigned DEF_DATA_W    = 16;
  localparam int unsigned DEF_SYNC_LEN  = 3;
  localparam int unsigned DEF_SHAPE_LEN = 2;

  // bits needed to hold a down-counter loaded with n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rd_sync_shaper.sv
`timescale 1ns/1ps
module rd_sync_shaper #(
  parameter int unsigned SYNC_LEN  = 3,
  parameter int unsigned SHAPE_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_n,
  output logic shp_n,
  output logic hit
);
  localparam int unsigned    CW   = mfm_sep_pkg::cnt_bits(SHAPE_LEN);
  localparam logic [CW-1:0]  LOAD = CW'(SHAPE_LEN);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       cnt_q;
  logic                fall;

  // capture chain: stage 0 samples the pin, stage SYNC_LEN-1 is oldest
  genvar i;
  generate
    for (i = 0; i < SYNC_LEN; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= rd_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b1;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign fall = sync_q[SYNC_LEN-1] & ~sync_q[SYNC_LEN-2];

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (fall)         cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign shp_n = (cnt_q == '0);
  assign hit   = (cnt_q == LOAD);
endmodule

// File: rtl/tri_sequencer.sv
`timescale 1ns/1ps
module tri_sequencer #(
  parameter int unsigned SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [SEQ_W-1:0] seq,
  output logic             msb
);
  logic [SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0] seq_d;

  // twisted ring: fills with ones, then drains, 2*SEQ_W states
  genvar i;
  generate
    for (i = 0; i < SEQ_W; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign seq_d[0] = ~seq_q[SEQ_W-1];
      end else begin : g_body
        assign seq_d[i] = seq_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) seq_q <= '0;
    else            seq_q <= seq_d;
  end

  assign seq = seq_q;
  assign msb = seq_q[SEQ_W-1];
endmodule

// File: rtl/cell_capture.sv
`timescale 1ns/1ps
module cell_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msb,
  input  logic              hit,
  output logic              tog,
  output logic              win,
  output logic [DATA_W-1:0] data,
  output logic              bit_valid
);
  logic              msb_q;
  logic              win_q;
  logic              flag_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign tog = msb & ~msb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_q   <= 1'b0;
      win_q   <= 1'b0;
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      msb_q   <= msb;
      valid_q <= tog;
      if (tog) begin
        win_q  <= ~win_q;
        data_q <= {data_q[DATA_W-2:0], flag_q};
        flag_q <= hit;          // a pulse on the boundary belongs to the new cell
      end else if (hit) begin
        flag_q <= 1'b1;
      end
    end
  end

  assign win       = win_q;
  assign data      = data_q;
  assign bit_valid = valid_q;
endmodule

// File: rtl/mfm_window_sep.sv
`timescale 1ns/1ps
module mfm_window_sep
  import mfm_sep_pkg::*;
#(
  parameter int unsigned SEQ_W     = DEF_SEQ_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned SYNC_LEN  = DEF_SYNC_LEN,
  parameter int unsigned SHAPE_LEN = DEF_SHAPE_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  output logic              win,
  output logic [DATA_W-1:0] data,
  output logic              bit_valid
);
  logic             shp_n;
  logic             hit;
  logic [SEQ_W-1:0] seq;
  logic             msb;
  logic             tog;

  rd_sync_shaper #(.SYNC_LEN(SYNC_LEN), .SHAPE_LEN(SHAPE_LEN)) u_shape (
    .clk(clk), .rst(rst), .rd_n(rd_n), .shp_n(shp_n), .hit(hit)
  );

  tri_sequencer #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst(rst), .clr(hit), .seq(seq), .msb(msb)
  );

  cell_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .msb(msb), .hit(hit), .tog(tog),
    .win(win), .data(data), .bit_valid(bit_valid)
  );
endmodule

// File: rtl/mfm_window_sep_chk.sv
`timescale 1ns/1ps
module mfm_window_sep_chk #(
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              shp_n,
  input logic              hit,
  input logic [SEQ_W-1:0]  seq,
  input logic              tog,
  input logic              win,
  input logic [DATA_W-1:0] data,
  input logic              bit_valid
);
  p_shape_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(shp_n) |-> (!$past(shp_n, 2) && $past(shp_n, 3)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> (seq == '0));

  p_strobe_phase_r4: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> ((seq == {{(SEQ_W-1){1'b1}}, 1'b0}) || $past(hit)));

  p_strobe_follows_r4: assert property (@(posedge clk) disable iff (rst)
    tog |=> bit_valid);

  p_win_flip_r6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (win != $past(win)));

  p_win_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> $stable(win));

  p_shift_r7: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (data[DATA_W-1:1] == $past(data[DATA_W-2:0])));

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);
endmodule

bind mfm_window_sep mfm_window_sep_chk #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .shp_n(shp_n), .hit(hit), .seq(seq), .tog(tog),
  .win(win), .data(data), .bit_valid(bit_valid)
);

// File: tb/mfm_window_sep_test.sv
`timescale 1ns/1ps
module mfm_window_sep_test;
  localparam int DW   = 16;
  localparam int MAXB = 2048;
  localparam int L    = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_n = 1'b1;
  logic          win;
  logic [DW-1:0] data;
  logic          bit_valid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  bit bits  [0:MAXB-1];
  int vtime [0:MAXB-1];
  int nbits = 0;
  bit pat   [0:L-1];

  logic          prev_win = 1'b0;
  logic          prev_valid = 1'b0;
  logic [DW-1:0] prev_data = '0;

  mfm_window_sep uut (
    .clk(clk), .rst(rst), .rd_n(rd_n),
    .win(win), .data(data), .bit_valid(bit_valid)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_all();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(negedge clk) begin
    if (!done && cyc > 60000) begin
      chk(1'b0, "watchdog", cyc, 60000);
      finish_all();
    end
  end

  // monitor: R6, R7, R9 on every cycle; record each recovered bit
  always @(negedge clk) begin
    if (armed) begin
      if (bit_valid) begin
        chk(win != prev_win, "R6 win flips on strobe", int'(win), int'(!prev_win));
        chk(data[DW-1:1] == prev_data[DW-2:0], "R7 shift toward MSB",
            int'(data), int'({prev_data[DW-2:0], data[0]}));
        chk(!prev_valid, "R9 strobe one cycle", int'(prev_valid), 0);
        if (nbits < MAXB) begin
          bits[nbits]  = data[0];
          vtime[nbits] = cyc;
          nbits++;
        end
      end else begin
        chk(win == prev_win, "R6 win steady", int'(win), int'(prev_win));
      end
    end
    prev_win   = win;
    prev_valid = bit_valid;
    prev_data  = data;
  end

  task automatic find_one(input int from_c, output int idx);
    idx = -1;
    for (int i = 0; i < nbits; i++)
      if (idx < 0 && vtime[i] >= from_c && bits[i]) idx = i;
  endtask

  task automatic wait_strobe_then(input int off);
    int n;
    n = nbits;
    while (nbits == n) @(negedge clk);
    repeat (off) @(negedge clk);
  endtask

  // single pulse; c1 is the counter value seen after the first capture edge
  task automatic pulse_trial(input int off, input int low_cycles, output int c1);
    wait_strobe_then(off);
    #0.5;
    rd_n = 1'b0;
    c1 = cyc + 1;
    repeat (low_cycles) @(negedge clk);
    rd_n = 1'b1;
    while (cyc < c1 + 70) @(negedge clk);
  endtask

  task automatic make_pattern(input logic [7:0] seed);
    logic [7:0] lf;
    int zr;
    lf = seed;
    zr = 0;
    for (int k = 0; k < L; k++) begin
      bit b;
      b = lf[0];
      if (k == 0 || zr == 3) b = 1'b1;
      pat[k] = b;
      zr = b ? 0 : zr + 1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
  endtask

  // R8: pulse train with period mode 0:76 1:80 2:84 3:cycling
  task automatic train_run(input int mode, input logic [7:0] seed);
    int n0;
    int idx;
    int p;
    make_pattern(seed);
    repeat (40) @(negedge clk);
    n0 = nbits;
    #1.3;
    for (int k = 0; k < L; k++) begin
      case (mode)
        0: p = 76;
        1: p = 80;
        2: p = 84;
        default: p = 76 + 4 * (k % 3);
      endcase
      if (pat[k]) begin
        rd_n = 1'b0;
        #12;
        rd_n = 1'b1;
        #(p - 12);
      end else begin
        #(p);
      end
    end
    repeat (80) @(negedge clk);
    idx = -1;
    for (int i = n0; i < nbits; i++) if (idx < 0 && bits[i]) idx = i;
    chk(idx >= 0, "R8 first pulse recovered", idx, n0);
    if (idx >= 0) begin
      for (int k = 0; k < L; k++) begin
        if (idx + k < nbits)
          chk(bits[idx + k] == pat[k], "R8 recovered bit", int'(bits[idx + k]), int'(pat[k]));
        else
          chk(1'b0, "R8 missing bit", idx + k, nbits);
      end
    end
  endtask

  initial begin
    int c1;
    int idx;
    int ones;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(win == 1'b0, "R1 win in reset", int'(win), 0);
    chk(data == '0, "R1 data in reset", int'(data), 0);
    chk(bit_valid == 1'b0, "R1 strobe in reset", int'(bit_valid), 0);
    rst = 1'b0;
    armed = 1'b1;
    @(negedge clk);
    chk(win == 1'b0 && data == '0 && bit_valid == 1'b0, "R1 first cycle after reset",
        int'({win, bit_valid}), 0);

    // R4: free-running strobes every 16 cycles, zeros
    while (nbits < 6) @(negedge clk);
    for (int i = 1; i < 6; i++) begin
      chk(vtime[i] - vtime[i-1] == 16, "R4 strobe spacing", vtime[i] - vtime[i-1], 16);
      chk(bits[i] == 1'b0, "R4 idle bit", int'(bits[i]), 0);
    end

    // R2 and R5 at two different phases
    for (int t = 0; t < 2; t++) begin
      pulse_trial((t == 0) ? 5 : 11, 3, c1);
      find_one(c1, idx);
      chk(idx >= 0, "R2 pulse recovered", idx, 0);
      if (idx >= 0) begin
        chk(vtime[idx] == c1 + 12, "R2 latency", vtime[idx] - c1, 12);
        chk(idx + 1 < nbits && vtime[idx + 1] == vtime[idx] + 16, "R5 next strobe",
            vtime[idx + 1] - vtime[idx], 16);
        chk(bits[idx + 1] == 1'b0, "R5 next bit empty", int'(bits[idx + 1]), 0);
      end
    end

    // R3: long low level counts once, strobes keep running
    pulse_trial(7, 40, c1);
    ones = 0;
    for (int i = 0; i < nbits; i++)
      if (vtime[i] >= c1 && vtime[i] <= c1 + 60 && bits[i]) ones++;
    chk(ones == 1, "R3 single pulse for long low", ones, 1);
    find_one(c1, idx);
    if (idx >= 0) begin
      chk(vtime[idx] == c1 + 12, "R3 pulse timing", vtime[idx] - c1, 12);
      chk(idx + 2 < nbits && vtime[idx + 2] == vtime[idx] + 32, "R3 strobes continue",
          vtime[idx + 2] - vtime[idx], 32);
    end else begin
      chk(1'b0, "R3 pulse missing", -1, 0);
    end

    // R8: drift and jitter trains
    train_run(0, 8'hA5);
    train_run(1, 8'h3C);
    train_run(2, 8'h5B);
    train_run(3, 8'hE7);

    finish_all();
  end
endmodule